// File: doc/BRIEF.md
# Initialization Record Fetch Sequencer

This block loads a network controller's operating parameters from an initialization record held in host memory. The host writes a 32-bit record address as two 16-bit halves, picks the logical entry width, and sets the INIT command. The sequencer then issues full 32-bit reads over a request/acknowledge read port. It unpacks each returned word into the mode register and into the base address and length registers of the receive and transmit descriptor rings.

A 16-bit layout packs two entries into each word and needs three reads. A 32-bit layout uses one word per entry and needs five reads. When the last field is stored, a done flag rises, and an interrupt follows if enabled. START issued with or during INIT turns the transmit and receive sections on only once done is set. STOP halts everything and aborts a fetch. After a STOP, the host can write the mode register directly and issue START to restart the sections without reading memory. The sequencer advances on every second clock.

Top module: `ninit_seq`

## Requirements
- R1: The record address is {ADDR_HI, ADDR_LO}, taken from host selects 1 and 0. Read k of a fetch goes to that address plus 4*k.
- R2: Writing CMD (select 4) with bit 0 (INIT) set starts a fetch, and busy is high for its duration. An INIT issued while busy is ignored. The fetch keeps its address and its read count.
- R3: With CFG (select 3) bit 0 set, the 32-bit layout applies. Five reads deliver, in order: mode (low 16 bits), receive base, transmit base, receive length (low 16 bits), transmit length (low 16 bits).
- R4: CFG bit 0 resets to 0, which selects the 16-bit layout. Three reads carry the halves, low half first, in the order mode, receive base, transmit base, receive length, transmit length. The bases are zero-extended, and the upper half of the third word is ignored.
- R5: rd_req stays high with a stable rd_addr until rd_ack is seen. It is low on the cycle after the acknowledge.
- R6: done rises after the last field is stored, and done and busy are never high together. irq equals done ANDed with CFG bit 1. CMD bit 3 clears done.
- R7: START (CMD bit 1), given together with or after INIT, leaves tx_on and rx_on low until done is set. Then tx_on = !mode[0] and rx_on = !mode[1].
- R8: STOP (CMD bit 2) clears tx_on, rx_on and done. It also aborts a fetch in progress, dropping busy and rd_req.
- R9: After STOP, a direct mode write (select 2) followed by START restarts the sections with the new mode, and no memory read takes place.
- R10: busy, done, tx_on and rx_on change only on alternate clock edges.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_en | input | 1 | Host register write strobe |
| hw_sel | input | 3 | Register select: 0 ADDR_LO, 1 ADDR_HI, 2 MODE, 3 CFG, 4 CMD |
| hw_data | input | 16 | Host write data |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 32 | Byte address of the word being read |
| rd_ack | input | 1 | Read acknowledge with valid data |
| rd_data | input | 32 | Returned read word |
| mode | output | 16 | Mode register |
| rx_base | output | 32 | Receive ring base |
| tx_base | output | 32 | Transmit ring base |
| rx_len | output | 16 | Receive ring length |
| tx_len | output | 16 | Transmit ring length |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | Initialization complete |
| irq | output | 1 | Interrupt request |
| tx_on | output | 1 | Transmit section running |
| rx_on | output | 1 | Receive section running |

## Verification
The assertions check on every cycle that the read handshake holds its address and drops after the acknowledge. They also check that done and busy are exclusive, that both sections stay off during a fetch, and that the sequencer outputs move only on alternate edges. Only the bench's scenarios can show the field unpacking for each layout, the read counts and addresses, that an INIT issued while busy is ignored, the STOP abort, and the restart path that involves no fetch.

// File: rtl/ninit_pkg.sv
package ninit_pkg;
  typedef enum logic [0:0] {S_IDLE, S_FETCH} seq_state_t;

  localparam logic [2:0] SEL_ADDR_LO = 3'd0;
  localparam logic [2:0] SEL_ADDR_HI = 3'd1;
  localparam logic [2:0] SEL_MODE    = 3'd2;
  localparam logic [2:0] SEL_CFG     = 3'd3;
  localparam logic [2:0] SEL_CMD     = 3'd4;

  localparam int CMD_INIT  = 0;
  localparam int CMD_START = 1;
  localparam int CMD_STOP  = 2;
  localparam int CMD_ACK   = 3;

  localparam int N_WIDE   = 5;
  localparam int N_NARROW = 3;
endpackage

// File: rtl/ninit_phase.sv
module ninit_phase (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic tick_q, tick_n;

  always_comb tick_n = ~tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_n;
  end

  assign tick = tick_q;
endmodule

// File: rtl/ninit_hostregs.sv
module ninit_hostregs
  import ninit_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hw_en,
  input  logic [2:0]          hw_sel,
  input  logic [HALF_W-1:0]   hw_data,
  input  logic                consume,
  output logic [2*HALF_W-1:0] base,
  output logic                wide,
  output logic                irq_en,
  output logic                pend_init,
  output logic                pend_start,
  output logic                pend_stop,
  output logic                pend_ack,
  output logic                mode_we
);
  logic [HALF_W-1:0] lo_q, lo_n, hi_q, hi_n;
  logic              wide_q, wide_n, ie_q, ie_n;
  logic [3:0]        pend_q, pend_n;

  always_comb begin
    lo_n   = lo_q;
    hi_n   = hi_q;
    wide_n = wide_q;
    ie_n   = ie_q;
    pend_n = consume ? 4'b0 : pend_q;
    if (hw_en) begin
      case (hw_sel)
        SEL_ADDR_LO: lo_n = hw_data;
        SEL_ADDR_HI: hi_n = hw_data;
        SEL_CFG: begin
          wide_n = hw_data[0];
          ie_n   = hw_data[1];
        end
        SEL_CMD: pend_n = pend_n | hw_data[3:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      wide_q <= 1'b0;
      ie_q   <= 1'b0;
      pend_q <= '0;
    end else begin
      lo_q   <= lo_n;
      hi_q   <= hi_n;
      wide_q <= wide_n;
      ie_q   <= ie_n;
      pend_q <= pend_n;
    end
  end

  assign base       = {hi_q, lo_q};
  assign wide       = wide_q;
  assign irq_en     = ie_q;
  assign pend_init  = pend_q[CMD_INIT];
  assign pend_start = pend_q[CMD_START];
  assign pend_stop  = pend_q[CMD_STOP];
  assign pend_ack   = pend_q[CMD_ACK];
  assign mode_we    = hw_en && (hw_sel == SEL_MODE);
endmodule

// File: rtl/ninit_unpack.sv
module ninit_unpack
  import ninit_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic                wide,
  input  logic [IDX_W-1:0]    idx,
  input  logic [2*HALF_W-1:0] word,
  output logic [4:0]          we,
  output logic [HALF_W-1:0]   v_mode,
  output logic [2*HALF_W-1:0] v_rxb,
  output logic [2*HALF_W-1:0] v_txb,
  output logic [HALF_W-1:0]   v_rxl,
  output logic [HALF_W-1:0]   v_txl,
  output logic                last
);
  localparam int WORD_W = 2 * HALF_W;
  logic [HALF_W-1:0] lo, hi;

  assign lo = word[HALF_W-1:0];
  assign hi = word[WORD_W-1:HALF_W];

  always_comb begin
    we     = '0;
    v_mode = lo;
    v_rxb  = word;
    v_txb  = word;
    v_rxl  = lo;
    v_txl  = lo;
    if (wide) begin
      last = (idx == IDX_W'(N_WIDE - 1));
      case (idx)
        IDX_W'(0): we[0] = 1'b1;
        IDX_W'(1): we[1] = 1'b1;
        IDX_W'(2): we[2] = 1'b1;
        IDX_W'(3): we[3] = 1'b1;
        IDX_W'(4): we[4] = 1'b1;
        default: ;
      endcase
    end else begin
      last  = (idx == IDX_W'(N_NARROW - 1));
      v_rxb = {{HALF_W{1'b0}}, hi};
      v_txb = {{HALF_W{1'b0}}, lo};
      v_rxl = hi;
      case (idx)
        IDX_W'(0): we = 5'b00011;
        IDX_W'(1): we = 5'b01100;
        IDX_W'(2): we = 5'b10000;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ninit_seq.sv
module ninit_seq
  import ninit_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hw_en,
  input  logic [2:0]          hw_sel,
  input  logic [HALF_W-1:0]   hw_data,
  output logic                rd_req,
  output logic [2*HALF_W-1:0] rd_addr,
  input  logic                rd_ack,
  input  logic [2*HALF_W-1:0] rd_data,
  output logic [HALF_W-1:0]   mode,
  output logic [2*HALF_W-1:0] rx_base,
  output logic [2*HALF_W-1:0] tx_base,
  output logic [HALF_W-1:0]   rx_len,
  output logic [HALF_W-1:0]   tx_len,
  output logic                busy,
  output logic                done,
  output logic                irq,
  output logic                tx_on,
  output logic                rx_on
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int BYTES  = WORD_W / 8;
  localparam int IDX_W  = $clog2(N_WIDE);

  logic              tick;
  logic [WORD_W-1:0] base;
  logic              wide, irq_en, p_init, p_start, p_stop, p_ack, mode_we;
  logic [4:0]        u_we;
  logic [HALF_W-1:0] u_mode, u_rxl, u_txl;
  logic [WORD_W-1:0] u_rxb, u_txb;
  logic              u_last;

  seq_state_t        st_q, st_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [WORD_W-1:0] fbase_q, fbase_n, wbuf_q, wbuf_n;
  logic              fwide_q, fwide_n, have_q, have_n, armed_q, armed_n;
  logic              done_q, done_n, txon_q, txon_n, rxon_q, rxon_n;
  logic [HALF_W-1:0] mode_q, mode_n, rxl_q, rxl_n, txl_q, txl_n;
  logic [WORD_W-1:0] rxb_q, rxb_n, txb_q, txb_n;

  ninit_phase u_phase (.clk(clk), .rst_n(rst_n), .tick(tick));

  ninit_hostregs #(.HALF_W(HALF_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_sel(hw_sel), .hw_data(hw_data),
    .consume(tick), .base(base), .wide(wide), .irq_en(irq_en),
    .pend_init(p_init), .pend_start(p_start), .pend_stop(p_stop),
    .pend_ack(p_ack), .mode_we(mode_we)
  );

  ninit_unpack #(.HALF_W(HALF_W), .IDX_W(IDX_W)) u_unpack (
    .wide(fwide_q), .idx(idx_q), .word(wbuf_q), .we(u_we),
    .v_mode(u_mode), .v_rxb(u_rxb), .v_txb(u_txb), .v_rxl(u_rxl),
    .v_txl(u_txl), .last(u_last)
  );

  always_comb begin
    st_n = st_q;    idx_n = idx_q;     fbase_n = fbase_q; fwide_n = fwide_q;
    have_n = have_q; wbuf_n = wbuf_q;  armed_n = armed_q;
    done_n = done_q; txon_n = txon_q;  rxon_n = rxon_q;
    mode_n = mode_q; rxb_n = rxb_q;    txb_n = txb_q;
    rxl_n = rxl_q;   txl_n = txl_q;
    if (rd_req && rd_ack) begin
      have_n = 1'b1;
      wbuf_n = rd_data;
    end
    if (mode_we) mode_n = hw_data;
    if (tick) begin
      if (p_ack) done_n = 1'b0;
      if (p_stop) begin
        st_n = S_IDLE; done_n = 1'b0; txon_n = 1'b0; rxon_n = 1'b0;
        armed_n = 1'b0; have_n = 1'b0;
      end else if (st_q == S_IDLE) begin
        if (p_init) begin
          st_n = S_FETCH; idx_n = '0; fbase_n = base; fwide_n = wide;
          done_n = 1'b0; txon_n = 1'b0; rxon_n = 1'b0;
          armed_n = p_start; have_n = 1'b0;
        end else if (p_start) begin
          txon_n = ~mode_q[0];
          rxon_n = ~mode_q[1];
        end
      end else begin
        if (p_start) armed_n = 1'b1;
        if (have_q) begin
          if (u_we[0]) mode_n = u_mode;
          if (u_we[1]) rxb_n  = u_rxb;
          if (u_we[2]) txb_n  = u_txb;
          if (u_we[3]) rxl_n  = u_rxl;
          if (u_we[4]) txl_n  = u_txl;
          have_n = 1'b0;
          idx_n  = idx_q + 1'b1;
          if (u_last) begin
            st_n   = S_IDLE;
            done_n = 1'b1;
            if (armed_q || p_start) begin
              txon_n = ~mode_q[0];
              rxon_n = ~mode_q[1];
            end
            armed_n = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_n_reset: begin end
      st_q <= S_IDLE;  idx_q <= '0;   fbase_q <= '0;  fwide_q <= 1'b0;
      have_q <= 1'b0;  wbuf_q <= '0;  armed_q <= 1'b0;
      done_q <= 1'b0;  txon_q <= 1'b0; rxon_q <= 1'b0;
      mode_q <= '0;    rxb_q <= '0;   txb_q <= '0;
      rxl_q <= '0;     txl_q <= '0;
    end else begin
      st_q <= st_n;    idx_q <= idx_n; fbase_q <= fbase_n; fwide_q <= fwide_n;
      have_q <= have_n; wbuf_q <= wbuf_n; armed_q <= armed_n;
      done_q <= done_n; txon_q <= txon_n; rxon_q <= rxon_n;
      mode_q <= mode_n; rxb_q <= rxb_n; txb_q <= txb_n;
      rxl_q <= rxl_n;  txl_q <= txl_n;
    end
  end

  assign busy    = (st_q == S_FETCH);
  assign rd_req  = busy && !have_q;
  assign rd_addr = fbase_q + (WORD_W'(idx_q) * WORD_W'(BYTES));
  assign mode    = mode_q;
  assign rx_base = rxb_q;
  assign tx_base = txb_q;
  assign rx_len  = rxl_q;
  assign tx_len  = txl_q;
  assign done    = done_q;
  assign irq     = done_q && irq_en;
  assign tx_on   = txon_q;
  assign rx_on   = rxon_q;
endmodule

// File: rtl/ninit_seq_chk.sv
module ninit_seq_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              rd_req,
  input logic              rd_ack,
  input logic [WORD_W-1:0] rd_addr,
  input logic              busy,
  input logic              done,
  input logic              tx_on,
  input logic              rx_on
);
  assert_req_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_ack |=> !rd_req);

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> (!rd_req || $stable(rd_addr)));

  assert_done_busy_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  assert_off_while_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!tx_on && !rx_on));

  assert_half_rate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> ($stable(done) && $stable(busy) && $stable(tx_on) && $stable(rx_on)));
endmodule

bind ninit_seq ninit_seq_chk #(.WORD_W(2*HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rd_req(rd_req), .rd_ack(rd_ack),
  .rd_addr(rd_addr), .busy(busy), .done(done), .tx_on(tx_on), .rx_on(rx_on)
);

// File: tb/tb_ninit_seq.sv
module tb_ninit_seq;
  typedef struct packed {
    logic [15:0] mode;
    logic [31:0] rxb;
    logic [31:0] txb;
    logic [15:0] rxl;
    logic [15:0] txl;
  } rec_t;

  logic        clk, rst_n, hw_en, rd_req, rd_ack, busy, done, irq, tx_on, rx_on;
  logic [2:0]  hw_sel;
  logic [15:0] hw_data, mode, rx_len, tx_len;
  logic [31:0] rd_addr, rd_data, rx_base, tx_base;

  ninit_seq dut (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_sel(hw_sel), .hw_data(hw_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .mode(mode), .rx_base(rx_base), .tx_base(tx_base), .rx_len(rx_len),
    .tx_len(tx_len), .busy(busy), .done(done), .irq(irq), .tx_on(tx_on), .rx_on(rx_on)
  );

  int checks = 0, errors = 0, reads = 0, lat = 2, r0;
  logic [31:0] last_addr, req_addr;
  logic [31:0] mem [0:63];
  rec_t exp_q[$];
  bit finished = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk); hw_en = 1'b1; hw_sel = sel; hw_data = d;
    @(negedge clk); hw_en = 1'b0;
  endtask

  task automatic wait_busy();
    for (int i = 0; i < 20 && !busy; i++) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000 && !(done && !busy); i++) @(negedge clk);
  endtask

  // memory responder: checks R5 address hold and request drop
  int cnt = 0;
  initial begin
    rd_ack = 1'b0; rd_data = '0;
    forever begin
      @(negedge clk);
      if (rd_ack) begin
        rd_ack = 1'b0;
        chk(!rd_req, "R5 req drops after ack", {31'b0, rd_req}, 32'd0);
      end else if (rd_req) begin
        if (cnt == 0) req_addr = rd_addr;
        if (cnt >= lat) begin
          chk(rd_addr == req_addr, "R5 address held", rd_addr, req_addr);
          rd_ack = 1'b1; rd_data = mem[rd_addr[7:2]];
          reads++; last_addr = rd_addr; cnt = 0;
        end else cnt++;
      end else cnt = 0;
    end
  end

  // scoreboard monitor plus R10 parity observation
  initial begin
    logic pd, pb;
    int cyc, par;
    pd = 0; pb = 0; cyc = 0; par = -1;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n && (busy != pb || done != pd)) begin
        if (par < 0) par = cyc % 2;
        chk((cyc % 2) == par, "R10 change on alternate edge", cyc % 2, par);
      end
      if (rst_n && done && !pd) begin
        if (exp_q.size() == 0) chk(0, "R3/R4 unexpected done", 1, 0);
        else begin
          rec_t e;
          e = exp_q.pop_front();
          chk(mode == e.mode, "R3/R4 mode", {16'b0, mode}, {16'b0, e.mode});
          chk(rx_base == e.rxb, "R3/R4 rx_base", rx_base, e.rxb);
          chk(tx_base == e.txb, "R3/R4 tx_base", tx_base, e.txb);
          chk(rx_len == e.rxl, "R3/R4 rx_len", {16'b0, rx_len}, {16'b0, e.rxl});
          chk(tx_len == e.txl, "R3/R4 tx_len", {16'b0, tx_len}, {16'b0, e.txl});
        end
      end
      pd = done; pb = busy;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    hw_en = 0; hw_sel = 0; hw_data = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk({busy, done, irq, tx_on, rx_on, rd_req} == 6'b0, "R11 flags zero",
        {26'b0, busy, done, irq, tx_on, rx_on, rd_req}, 0);
    chk(mode == 0 && rx_base == 0 && tx_base == 0 && rx_len == 0 && tx_len == 0,
        "R11 fields zero", rx_base | tx_base, 0);

    // T1: narrow layout (default), INIT+START together, high address half used
    mem[16] = {16'h1234, 16'h0001};
    mem[17] = {16'h0010, 16'h5678};
    mem[18] = {16'hDEAD, 16'h0020};
    exp_q.push_back('{16'h0001, 32'h1234, 32'h5678, 16'h0010, 16'h0020});
    hwrite(3'd0, 16'h0040);
    hwrite(3'd1, 16'h0001);
    r0 = reads;
    hwrite(3'd4, 16'h0003);
    wait_busy();
    chk(busy, "R2 busy after INIT", {31'b0, busy}, 1);
    chk(!tx_on && !rx_on, "R7 off before done", {30'b0, tx_on, rx_on}, 0);
    wait_done();
    chk(reads - r0 == 3, "R4 three reads", reads - r0, 3);
    chk(last_addr == 32'h0001_0048, "R1 last read address", last_addr, 32'h0001_0048);
    chk(!tx_on && rx_on, "R7 sections per mode", {30'b0, tx_on, rx_on}, 1);
    chk(!irq, "R6 irq masked", {31'b0, irq}, 0);
    hwrite(3'd4, 16'h0008);
    repeat (3) @(negedge clk);
    chk(!done, "R6 ack clears done", {31'b0, done}, 0);

    // T2: wide layout, interrupt enabled, START after done
    mem[32] = 32'hBEEF_0000; mem[33] = 32'h1234_5600; mem[34] = 32'h9ABC_DE00;
    mem[35] = 32'h7777_0100; mem[36] = 32'h5555_0200;
    exp_q.push_back('{16'h0000, 32'h1234_5600, 32'h9ABC_DE00, 16'h0100, 16'h0200});
    hwrite(3'd3, 16'h0003);
    hwrite(3'd0, 16'h0080);
    hwrite(3'd1, 16'h0000);
    lat = 3; r0 = reads;
    hwrite(3'd4, 16'h0001);
    wait_busy(); wait_done();
    chk(reads - r0 == 5, "R3 five reads", reads - r0, 5);
    chk(last_addr == 32'h90, "R1 wide last address", last_addr, 32'h90);
    chk(irq, "R6 irq when enabled", {31'b0, irq}, 1);
    chk(!tx_on && !rx_on, "R7 no start given", {30'b0, tx_on, rx_on}, 0);
    hwrite(3'd4, 16'h0002);
    repeat (3) @(negedge clk);
    chk(tx_on && rx_on, "R7 start after done", {30'b0, tx_on, rx_on}, 3);

    // T3: INIT while busy is ignored
    mem[48] = {16'hAAAA, 16'h0000};
    mem[49] = {16'h0030, 16'hBBBB};
    mem[50] = {16'h1111, 16'h0040};
    exp_q.push_back('{16'h0000, 32'hAAAA, 32'hBBBB, 16'h0030, 16'h0040});
    hwrite(3'd3, 16'h0000);
    hwrite(3'd0, 16'h00C0);
    lat = 4; r0 = reads;
    hwrite(3'd4, 16'h0001);
    wait_busy();
    hwrite(3'd0, 16'h0040);
    hwrite(3'd4, 16'h0001);
    wait_done();
    chk(reads - r0 == 3, "R2 reads unchanged by second INIT", reads - r0, 3);
    chk(last_addr == 32'hC8, "R2 address kept", last_addr, 32'hC8);

    // T4: STOP aborts a fetch
    lat = 100000; r0 = reads;
    hwrite(3'd4, 16'h0001);
    wait_busy();
    hwrite(3'd4, 16'h0004);
    repeat (3) @(negedge clk);
    chk(!busy && !rd_req && !done, "R8 fetch aborted", {29'b0, busy, rd_req, done}, 0);
    chk(reads == r0, "R8 no read completed", reads - r0, 0);
    lat = 2;

    // T5: STOP, direct mode write, START
    hwrite(3'd4, 16'h0002);
    repeat (3) @(negedge clk);
    chk(tx_on && rx_on, "R9 start from idle", {30'b0, tx_on, rx_on}, 3);
    hwrite(3'd4, 16'h0004);
    repeat (3) @(negedge clk);
    chk(!tx_on && !rx_on, "R8 stop clears sections", {30'b0, tx_on, rx_on}, 0);
    r0 = reads;
    hwrite(3'd2, 16'h0002);
    hwrite(3'd4, 16'h0002);
    repeat (3) @(negedge clk);
    chk(tx_on && !rx_on, "R9 new mode applied", {30'b0, tx_on, rx_on}, 2);
    chk(mode == 16'h0002, "R9 mode register", {16'b0, mode}, 2);
    chk(reads == r0 && !busy, "R9 no fetch", reads - r0, 0);
    chk(exp_q.size() == 0, "R3/R4 scoreboard drained", exp_q.size(), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule